// File: doc/BRIEF.md
# Pin-Controlled Power-Down Hold Controller

This block freezes a surrounding logic design while a power-down request is present. Two request pins feed an OR, which is gated by a configuration bit. The gated request passes through a two-flop synchroniser into the system clock domain. Once the synchronised request is high, the block stops sampling its input data bus, its internal state bus, its output values and its output enables. Every held copy then keeps the value it last captured. When both request pins return low, the same synchroniser path releases the hold and normal sampling resumes.

When the configuration bit is set, the two request pins are reserved for power-down and are removed from the logic input path. When the bit is clear, the pins act as two ordinary registered logic inputs and no hold ever occurs. Outputs are modelled as a value bus plus an enable bus. A bit whose enable is low reads as 0 and stays undriven for the whole hold.

Top module: `pd_hold`

## Requirements
- R1: After reset every output bus, the reported control-pin bus and `holdActive` are 0.
- R2: While no hold is in effect, `dataOut`, `stateOut`, `oeOut` and `outOut` show, one clock edge later, the values presented at the previous rising edge. `outOut` bit i equals `outIn[i] & oeIn[i]`.
- R3: With `featEn`=1, a request pin that goes high before rising edge 1 sets `holdActive` after edge 3. All held outputs keep the values captured at edge 2.
- R4: The request is the OR of `pdA` and `pdB`: `pdA` alone, `pdB` alone, or both each produce the same hold.
- R5: While `holdActive` is 1, changes on `dataIn` have no effect on `dataOut`.
- R6: While `holdActive` is 1, `stateOut` keeps its held value whatever `stateIn` does.
- R7: While `holdActive` is 1, enabled output bits keep their last driven value. Bits whose enable was low stay disabled (`oeOut` bit 0, `outOut` bit 0) whatever `oeIn` and `outIn` do.
- R8: When both request pins go low before rising edge 1, capture resumes at edge 3 and `holdActive` falls after that edge.
- R9: With `featEn`=0, request pins never cause a hold. `ctlPinsOut` = {`pdB`,`pdA`} sampled at the previous edge.
- R10: With `featEn`=1, `ctlPinsOut` reads 0 whatever the request pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| featEn | input | 1 | Configuration bit that enables the power-down feature |
| pdA | input | 1 | First power-down request pin |
| pdB | input | 1 | Second power-down request pin |
| dataIn | input | IN_W | Input pin data |
| stateIn | input | ST_W | Internal state to be tracked |
| outIn | input | OUT_W | Output values |
| oeIn | input | OUT_W | Output enables |
| dataOut | output | IN_W | Held input data |
| stateOut | output | ST_W | Held internal state |
| outOut | output | OUT_W | Held output values, 0 where disabled |
| oeOut | output | OUT_W | Held output enables |
| ctlPinsOut | output | 2 | Request pins as logic inputs, {pdB,pdA}; 0 when reserved |
| holdActive | output | 1 | High while the hold is in effect |

## Verification
Every registered output follows its input one rising edge after the input changes. The bench therefore drives inputs on falling edges and checks them at the next falling edge. A request pin takes three rising edges to freeze the outputs: two for the synchroniser and one for the hold. The release path has the same three-edge timing. The bench steps exactly that many edges before each entry and exit check, and asserts that the values are those captured at the second edge. During a hold it sweeps every input value of a small four-bit configuration and confirms the outputs do not move.

// File: rtl/pd_hold_pkg.sv
package pd_hold_pkg;
  typedef struct packed {
    logic freeze;    // suppress capture on this edge
    logic holdState; // hold in effect (registered)
  } pdStrobe_t;
endpackage

// File: rtl/pd_hold_ctl.sv
module pd_hold_ctl
  import pd_hold_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      featEn,
  input  logic      pdA,
  input  logic      pdB,
  output pdStrobe_t strobe
);
  localparam int LAST = SYNC_STAGES - 1;

  logic             rawReq;
  logic [LAST:0]    syncQ;
  logic             holdQ;

  assign rawReq = featEn & (pdA | pdB);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      holdQ <= 1'b0;
    end else begin
      syncQ[0] <= rawReq;
      holdQ    <= syncQ[LAST];
    end
  end

  for (genvar i = 1; i < SYNC_STAGES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[i] <= 1'b0;
      else       syncQ[i] <= syncQ[i-1];
    end
  end

  assign strobe.freeze    = syncQ[LAST];
  assign strobe.holdState = holdQ;

  // R8
  hold_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncQ[LAST] |=> !holdQ);
  // R9
  no_hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!featEn && !syncQ[0]) |=> !syncQ[0]);
endmodule

// File: rtl/pd_hold_dp.sv
module pd_hold_dp
  import pd_hold_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ST_W  = 8,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             featEn,
  input  logic             pdA,
  input  logic             pdB,
  input  pdStrobe_t        strobe,
  input  logic [IN_W-1:0]  dataIn,
  input  logic [ST_W-1:0]  stateIn,
  input  logic [OUT_W-1:0] outIn,
  input  logic [OUT_W-1:0] oeIn,
  output logic [IN_W-1:0]  dataOut,
  output logic [ST_W-1:0]  stateOut,
  output logic [OUT_W-1:0] outOut,
  output logic [OUT_W-1:0] oeOut,
  output logic [1:0]       ctlPinsOut
);
  logic [IN_W-1:0]  dataReg;
  logic [ST_W-1:0]  stateReg;
  logic [OUT_W-1:0] outReg;
  logic [OUT_W-1:0] oeReg;
  logic [1:0]       pinReg;
  logic [1:0]       pinNext;

  assign pinNext = featEn ? 2'b00 : {pdB, pdA};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg  <= '0;
      stateReg <= '0;
      outReg   <= '0;
      oeReg    <= '0;
      pinReg   <= '0;
    end else begin
      pinReg <= pinNext;
      if (!strobe.freeze) begin
        dataReg  <= dataIn;
        stateReg <= stateIn;
        outReg   <= outIn;
        oeReg    <= oeIn;
      end
    end
  end

  for (genvar b = 0; b < OUT_W; b++) begin : g_drv
    assign outOut[b] = oeReg[b] & outReg[b];
  end

  assign dataOut    = dataReg;
  assign stateOut   = stateReg;
  assign oeOut      = oeReg;
  assign ctlPinsOut = pinReg;

  // R2
  track_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.freeze |=> dataReg == $past(dataIn));
  // R5
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.freeze |=> $stable(dataReg));
  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.freeze |=> $stable(stateReg));
  // R7
  tristate_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.freeze && strobe.holdState) |=> $stable(oeReg) && $stable(outOut));
  // R10
  pins_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    featEn |=> ctlPinsOut == 2'b00);
endmodule

// File: rtl/pd_hold.sv
module pd_hold
  import pd_hold_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int ST_W  = 8,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             featEn,
  input  logic             pdA,
  input  logic             pdB,
  input  logic [IN_W-1:0]  dataIn,
  input  logic [ST_W-1:0]  stateIn,
  input  logic [OUT_W-1:0] outIn,
  input  logic [OUT_W-1:0] oeIn,
  output logic [IN_W-1:0]  dataOut,
  output logic [ST_W-1:0]  stateOut,
  output logic [OUT_W-1:0] outOut,
  output logic [OUT_W-1:0] oeOut,
  output logic [1:0]       ctlPinsOut,
  output logic             holdActive
);
  pdStrobe_t strobe;

  pd_hold_ctl #(.SYNC_STAGES(2)) u_ctl (
    .clk(clk), .rstN(rstN), .featEn(featEn), .pdA(pdA), .pdB(pdB),
    .strobe(strobe)
  );

  pd_hold_dp #(.IN_W(IN_W), .ST_W(ST_W), .OUT_W(OUT_W)) u_dp (
    .clk(clk), .rstN(rstN), .featEn(featEn), .pdA(pdA), .pdB(pdB),
    .strobe(strobe), .dataIn(dataIn), .stateIn(stateIn), .outIn(outIn),
    .oeIn(oeIn), .dataOut(dataOut), .stateOut(stateOut), .outOut(outOut),
    .oeOut(oeOut), .ctlPinsOut(ctlPinsOut)
  );

  assign holdActive = strobe.holdState;

  // R3
  hold_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdActive) |-> $past(strobe.freeze));
endmodule

// File: tb/sim_pd_hold.sv
module sim_pd_hold;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic featEn = 1'b0, pdA = 1'b0, pdB = 1'b0;
  logic [W-1:0] dataIn = '0, stateIn = '0, outIn = '0, oeIn = '0;
  logic [W-1:0] dataOut, stateOut, outOut, oeOut;
  logic [1:0] ctlPinsOut;
  logic holdActive;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pd_hold #(.IN_W(W), .ST_W(W), .OUT_W(W)) u0 (
    .clk(clk), .rstN(rstN), .featEn(featEn), .pdA(pdA), .pdB(pdB),
    .dataIn(dataIn), .stateIn(stateIn), .outIn(outIn), .oeIn(oeIn),
    .dataOut(dataOut), .stateOut(stateOut), .outOut(outOut), .oeOut(oeOut),
    .ctlPinsOut(ctlPinsOut), .holdActive(holdActive)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [W-1:0] d, logic [W-1:0] s, logic [W-1:0] o, logic [W-1:0] e);
    dataIn = d; stateIn = s; outIn = o; oeIn = e;
  endtask

  // one rising edge, return at the following falling edge
  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chkAll(string req, logic [W-1:0] d, logic [W-1:0] s,
                        logic [W-1:0] o, logic [W-1:0] e, logic h);
    chk(req, dataOut, d);
    chk(req, stateOut, s);
    chk(req, outOut, o & e);
    chk(req, oeOut, e);
    chk(req, holdActive, h);
  endtask

  task automatic holdCycle(logic [1:0] sel);
    logic [W-1:0] oeMask;
    oeMask = 4'b0101 ^ {2'b00, sel};
    featEn = 1'b1;
    drive(4'h3, 4'hC, 4'hF, oeMask);
    {pdB, pdA} = sel;
    step(); // edge 1
    chk("R10", ctlPinsOut, 0);
    chkAll("R4", 4'h3, 4'hC, 4'hF, oeMask, 1'b0);
    drive(4'hA, 4'h5, 4'hF, oeMask);
    step(); // edge 2: last capture
    chkAll("R3", 4'hA, 4'h5, 4'hF, oeMask, 1'b0);
    drive(4'h1, 4'h2, 4'h0, 4'hF);
    step(); // edge 3: hold in effect
    chkAll("R3", 4'hA, 4'h5, 4'hF, oeMask, 1'b1);
    for (int v = 0; v < 16; v++) begin
      drive(v[W-1:0], ~v[W-1:0], v[W-1:0] ^ 4'h9, 4'hF);
      step();
      chk("R5", dataOut, 4'hA);
      chk("R6", stateOut, 4'h5);
      chk("R7", outOut, 4'hF & oeMask);
      chk("R7", oeOut, oeMask);
      chk("R10", ctlPinsOut, 0);
    end
    {pdB, pdA} = 2'b00;
    drive(4'h6, 4'h9, 4'hA, 4'hC);
    step(); // release edge 1
    chkAll("R8", 4'hA, 4'h5, 4'hF, oeMask, 1'b1);
    step(); // release edge 2
    chkAll("R8", 4'hA, 4'h5, 4'hF, oeMask, 1'b1);
    step(); // release edge 3: capture resumes
    chkAll("R8", 4'h6, 4'h9, 4'hA, 4'hC, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    drive(4'hF, 4'hF, 4'hF, 4'hF);
    {pdB, pdA} = 2'b11;
    step(); step();
    chkAll("R1", 0, 0, 0, 0, 1'b0);
    chk("R1", ctlPinsOut, 0);
    rstN = 1'b1;
    {pdB, pdA} = 2'b00;

    // R2: tracking sweep, feature enabled but idle
    featEn = 1'b1;
    for (int v = 0; v < 16; v++) begin
      drive(v[W-1:0], v[W-1:0] ^ 4'h6, v[W-1:0], ~v[W-1:0]);
      step();
      chkAll("R2", v[W-1:0], v[W-1:0] ^ 4'h6, v[W-1:0], ~v[W-1:0], 1'b0);
    end

    // R3 R4 R5 R6 R7 R8 for each request pin combination
    holdCycle(2'b01);
    holdCycle(2'b10);
    holdCycle(2'b11);

    // R9: feature off, pins are plain inputs
    featEn = 1'b0;
    step();
    for (int p = 0; p < 4; p++) begin
      for (int v = 0; v < 4; v++) begin
        {pdB, pdA} = p[1:0];
        drive(v[W-1:0] + 4'h4 * p[W-1:0], 4'h0, 4'h3, 4'h1);
        step();
        chk("R9", ctlPinsOut, p);
        chk("R9", holdActive, 0);
        chk("R9", dataOut, v + 4 * p);
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule